// File: doc/BRIEF.md
# Key-Locked Watchdog Timer

This block is a watchdog timer that sits on a simple register bus. The bus has an address, a write strobe, write data and combinational read data. Its configuration register is guarded by a two-write key sequence. A control write carrying the opening key in bits 23:16 arms the lock. The very next bus write is accepted only if it goes to the control register and carries the commit key. That accepted write loads the enable, a pass-through power field, the prescaler select and a 16-bit reload value. Any other write to the control register has no effect.

While enabled, a prescaler divides the clock by one of four ratios, and each prescaled tick decrements a 16-bit counter. When a tick finds the count at 1 or below, the counter has run out. The block then pulses a reset request for one clock, reloads the counter and sets a sticky cause flag. Software clears the flag by writing a 1 to it. Software keeps the system alive by repeating the full key sequence before the count runs out, since every accepted sequence reloads the counter and restarts the prescaler.

Top module: `pwlock_wdog`

## Requirements
- R1: After reset, both registers read as zero, `rst_req` is low and the lock is not armed.
- R2: A control write (offset 0x0) with bits 23:16 = 0xBE, followed by the very next bus write going to control with bits 23:16 = 0xDC, is accepted. The accepted write stores bit 31 (enable), bits 27:26 (power field), bits 25:24 (divider select) and bits 15:0 (reload), and loads the counter with the reload value.
- R3: A control write that is not part of an armed sequence leaves the configuration and the counter unchanged. This includes a lone write carrying the 0xDC key.
- R4: After the opening write, if the next bus write is anything other than a control write carrying 0xDC, the lock disarms. This covers a control write with a different key and any status write. A following 0xDC write is then ignored.
- R5: Divider select values 0, 1, 2 and 3 give one counter tick every 1, 64, 4096 and 262144 clocks. The prescaler restarts from zero on every accepted write.
- R6: While enabled, each tick decrements the counter. A tick that finds the count at 1 or below is an expiry: `rst_req` goes high for one clock on the next edge and the counter reloads. A count loaded with N therefore expires N ticks after the accepted write (N of 0 behaves like 1).
- R7: An accepted write with bit 31 clear stops counting. While disabled, no `rst_req` pulse occurs.
- R8: Status bit 31 is a sticky watchdog-cause flag. An expiry sets it. Writing status (offset 0x8) with bit 31 set clears it, and writing 0 there leaves it unchanged. An expiry in the same clock as a clearing write wins.
- R9: Reading status returns the flag in bit 31, the enable in bit 30, the divider in bits 25:24 and the live count in bits 15:0. Reading control returns the enable in bit 31, the power field in bits 27:26, the divider in bits 25:24 and the reload in bits 15:0. All other bits and addresses read 0.
- R10: Repeating the key sequence before expiry reloads the counter and prescaler and prevents `rst_req`. An accepted write in the same clock as an expiry cancels that expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| rst_req | output | 1 | One-clock system reset request on expiry |

## Verification
Some properties are checked on every cycle by the assertions:
- the count never exceeds the stored reload value;
- the counter holds still while disabled;
- a reset request only follows an enabled state and always comes with the cause flag;
- the flag moves only on an expiry or a status write;
- a control write made while the lock is not armed never alters the configuration.

Other behaviour can only be shown by the bench's scenarios, which compare the block with a behavioural model on every clock:
- the exact expiry cycle for each divider ratio;
- aborted and out-of-order key sequences;
- refreshes that postpone expiry;
- the layout of the read-back fields.

// File: rtl/pwlock_wdog.sv
module pwlock_wdog #(
  parameter int          ADDR_W     = 4,
  parameter int          CNT_W      = 16,
  parameter int          DIV_STEP   = 6,
  parameter logic [7:0]  KEY_OPEN   = 8'hBE,
  parameter logic [7:0]  KEY_COMMIT = 8'hDC,
  parameter int          CTRL_OFS   = 0,
  parameter int          STAT_OFS   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              rst_req
);
  localparam int PRE_W = 3 * DIV_STEP;
  localparam int SH_W  = $clog2(PRE_W + 1);

  logic             armed_q, en_q, flag_q;
  logic [1:0]       pwr_q, div_q;
  logic [CNT_W-1:0] reload_q, cnt_q;
  logic [PRE_W-1:0] pre_q;

  logic ctl_sel, stat_sel, ctl_wr, stat_wr, accept, tick, expire;
  logic [7:0]       key;
  logic [SH_W-1:0]  shamt;
  logic [PRE_W-1:0] pre_mask;

  assign ctl_sel  = bus_addr == ADDR_W'(CTRL_OFS);
  assign stat_sel = bus_addr == ADDR_W'(STAT_OFS);
  assign ctl_wr   = bus_we && ctl_sel;
  assign stat_wr  = bus_we && stat_sel;
  assign key      = bus_wdata[23:16];
  assign accept   = ctl_wr && armed_q && key == KEY_COMMIT;

  assign shamt    = SH_W'(div_q) * SH_W'(DIV_STEP);
  assign pre_mask = (PRE_W'(1) << shamt) - PRE_W'(1);
  assign tick     = en_q && pre_q == pre_mask;
  assign expire   = tick && cnt_q <= CNT_W'(1) && !accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
    end else if (bus_we) begin
      armed_q <= !armed_q && ctl_wr && key == KEY_OPEN;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      pwr_q    <= '0;
      div_q    <= '0;
      reload_q <= '0;
    end else if (accept) begin
      en_q     <= bus_wdata[31];
      pwr_q    <= bus_wdata[27:26];
      div_q    <= bus_wdata[25:24];
      reload_q <= bus_wdata[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (accept) begin
      pre_q <= '0;
      cnt_q <= bus_wdata[CNT_W-1:0];
    end else begin
      if (tick)      pre_q <= '0;
      else if (en_q) pre_q <= pre_q + PRE_W'(1);
      if (expire)    cnt_q <= reload_q;
      else if (tick) cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_req <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      rst_req <= expire;
      if (expire)                      flag_q <= 1'b1;
      else if (stat_wr && bus_wdata[31]) flag_q <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (ctl_sel) begin
      bus_rdata[31]      = en_q;
      bus_rdata[27:26]   = pwr_q;
      bus_rdata[25:24]   = div_q;
      bus_rdata[CNT_W-1:0] = reload_q;
    end else if (stat_sel) begin
      bus_rdata[31]      = flag_q;
      bus_rdata[30]      = en_q;
      bus_rdata[25:24]   = div_q;
      bus_rdata[CNT_W-1:0] = cnt_q;
    end
  end
endmodule

// File: rtl/pwlock_wdog_chk.sv
module pwlock_wdog_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rst_req,
  input logic             armed_q,
  input logic             ctl_wr,
  input logic             stat_wr,
  input logic             accept,
  input logic             expire,
  input logic             en_q,
  input logic             flag_q,
  input logic [1:0]       div_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] reload_q
);
  assert_cnt_le_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= reload_q);

  assert_hold_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !accept) |=> $stable(cnt_q));

  assert_req_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> $past(en_q));

  assert_req_sets_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> flag_q);

  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!expire && !stat_wr) |=> $stable(flag_q));

  assert_locked_write_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !armed_q) |=> ($stable(en_q) && $stable(div_q) && $stable(reload_q)));
endmodule

bind pwlock_wdog pwlock_wdog_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .armed_q(armed_q),
  .ctl_wr(ctl_wr), .stat_wr(stat_wr), .accept(accept), .expire(expire),
  .en_q(en_q), .flag_q(flag_q), .div_q(div_q), .cnt_q(cnt_q), .reload_q(reload_q)
);

// File: tb/test_pwlock_wdog.sv
module test_pwlock_wdog;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rst_req;

  pwlock_wdog i_pwlock_wdog (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rst_req(rst_req)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    errors = 0;
  int    checks = 0;
  string cur_req = "R1";

  int m_armed, m_en, m_pwr, m_div, m_reload, m_cnt, m_pre, m_flag, m_rst;
  int acc, tk, ex, cw, sw;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_armed = 0; m_en = 0; m_pwr = 0; m_div = 0; m_reload = 0;
      m_cnt = 0; m_pre = 0; m_flag = 0; m_rst = 0;
    end else begin
      cw  = (bus_we && bus_addr == 4'h0) ? 1 : 0;
      sw  = (bus_we && bus_addr == 4'h8) ? 1 : 0;
      acc = (cw != 0 && m_armed != 0 && bus_wdata[23:16] == 8'hDC) ? 1 : 0;
      tk  = (m_en != 0 && m_pre == (1 << (6 * m_div)) - 1) ? 1 : 0;
      ex  = (tk != 0 && m_cnt <= 1 && acc == 0) ? 1 : 0;
      m_rst = ex;
      if (ex != 0) m_flag = 1;
      else if (sw != 0 && bus_wdata[31]) m_flag = 0;
      if (bus_we) m_armed = (m_armed == 0 && cw != 0 && bus_wdata[23:16] == 8'hBE) ? 1 : 0;
      if (acc != 0) begin
        m_en = int'(bus_wdata[31]); m_pwr = int'(bus_wdata[27:26]);
        m_div = int'(bus_wdata[25:24]); m_reload = int'(bus_wdata[15:0]);
        m_cnt = m_reload; m_pre = 0;
      end else begin
        if (tk != 0) m_pre = 0;
        else if (m_en != 0) m_pre = m_pre + 1;
        if (ex != 0) m_cnt = m_reload;
        else if (tk != 0) m_cnt = m_cnt - 1;
      end
    end
  end

  function automatic logic [31:0] exp_rd(input logic [3:0] a);
    logic [31:0] r = '0;
    if (a == 4'h0) begin
      r[31] = m_en[0]; r[27:26] = m_pwr[1:0]; r[25:24] = m_div[1:0]; r[15:0] = m_reload[15:0];
    end else if (a == 4'h8) begin
      r[31] = m_flag[0]; r[30] = m_en[0]; r[25:24] = m_div[1:0]; r[15:0] = m_cnt[15:0];
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    check({cur_req, " rst_req vs model"}, {31'd0, rst_req}, {31'd0, m_rst[0]});
    check({cur_req, " rdata vs model"}, bus_rdata, exp_rd(bus_addr));
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    step();
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic cfg(input logic [31:0] d);
    wr(4'h0, 32'h00BE0000);
    wr(4'h0, d);
  endtask

  task automatic until_req(input int limit, output int n);
    n = -1;
    for (int i = 1; i <= limit; i++) begin
      step();
      if (rst_req && n < 0) n = i;
      if (n >= 0) break;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int n, seen;

    cur_req = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    rd(4'h0, v); check("R1 control after reset", v, 32'h0);
    rd(4'h8, v); check("R1 status after reset", v, 32'h0);
    check("R1 rst_req after reset", {31'd0, rst_req}, 32'h0);

    cur_req = "R3";
    wr(4'h0, 32'h80DC0005);
    wr(4'h0, 32'h12345678);
    rd(4'h0, v); check("R3 lone commit ignored", v, 32'h0);
    repeat (5) step();

    cur_req = "R2";
    cfg(32'h8CDC0005);
    rd(4'h0, v); check("R2 control fields", v, 32'h8C000005);
    rd(4'h8, v); check("R2 status count loaded", v[15:0], 32'h5);

    cur_req = "R6";
    until_req(50, n);
    check("R6 expiry after 5 ticks at divide 1", n, 32'd5);
    step();
    check("R6 rst_req single cycle", {31'd0, rst_req}, 32'h0);
    rd(4'h8, v); check("R8 flag set by expiry", {31'd0, v[31]}, 32'h1);

    cur_req = "R7";
    cfg(32'h00DC0000);
    seen = 0;
    for (int i = 0; i < 40; i++) begin step(); if (rst_req) seen = 1; end
    check("R7 no request while disabled", seen, 0);
    rd(4'h8, v); check("R7 count held at zero", v[15:0], 32'h0);

    cur_req = "R8";
    wr(4'h8, 32'h0);
    rd(4'h8, v); check("R8 write 0 keeps flag", {31'd0, v[31]}, 32'h1);
    wr(4'h8, 32'h80000000);
    rd(4'h8, v); check("R8 write 1 clears flag", {31'd0, v[31]}, 32'h0);

    cur_req = "R4";
    wr(4'h0, 32'h00BE0000);
    wr(4'h0, 32'h00BE0000);
    wr(4'h0, 32'h80DC0007);
    rd(4'h0, v); check("R4 abort by wrong second key", v, 32'h0);
    wr(4'h0, 32'h00BE0000);
    wr(4'h8, 32'h0);
    wr(4'h0, 32'h80DC0007);
    rd(4'h0, v); check("R4 abort by status write", v, 32'h0);

    cur_req = "R5";
    cfg(32'h81DC0003);
    until_req(400, n);
    check("R5 divide 64 reload 3 expiry", n, 32'd192);
    cfg(32'h00DC0000);

    cur_req = "R10";
    cfg(32'h81DC0003);
    seen = 0;
    for (int k = 0; k < 4; k++) begin
      for (int i = 0; i < 150; i++) begin step(); if (rst_req) seen = 1; end
      cfg(32'h81DC0003);
    end
    check("R10 refresh prevents expiry", seen, 0);
    repeat (100) step();
    cfg(32'h81DC0003);
    until_req(400, n);
    check("R10 prescaler restarts on refresh", n, 32'd192);

    cur_req = "R9";
    wr(4'h8, 32'h80000000);
    cfg(32'h82DC0002);
    rd(4'h8, v); check("R9 status layout", v, 32'h42000002);
    cur_req = "R5";
    until_req(9000, n);
    check("R5 divide 4096 reload 2 expiry", n, 32'd8192);

    cfg(32'h83DC0001);
    seen = 0;
    for (int i = 0; i < 3000; i++) begin step(); if (rst_req) seen = 1; end
    check("R5 divide 262144 no early tick", seen, 0);
    rd(4'h8, v); check("R5 divide 262144 count held", v[15:0], 32'h1);
    cfg(32'h00DC0000);
    repeat (5) step();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule